// File: doc/BRIEF.md
# Programmable Chip Select Timing Generator

This block produces the strobes for one memory-mapped peripheral region on a simple processor bus. These strobes are chip select, output enable, write enable, a read/write direction line, transfer acknowledge and burst inhibit. A base address and a block size place the region in the address space. An option word sets the timing of each access. The block runs on a clock at four times the bus rate, so every strobe edge falls on a quarter-bus-clock tick.

The bus master raises `reqStart` for one fast clock, together with an address and a direction. The block accepts this only on the fast clock that opens a bus clock. If the address is inside the window, the block runs the access. Chip select can be delayed by a quarter or a half bus clock, and a relaxed mode can push it out by a whole bus clock. The block can also add one bus clock to the first access to the region. It then ends the access in one of two ways: it counts a programmed number of wait states and pulses its own acknowledge, or it waits for the peripheral's acknowledge. An early-negate option pulls chip select and write enable back half a bus clock before the access ends. An access may start on the bus clock right after the previous one ends.

Top module: `cs_timing_gen`

## Requirements
- R1: An access starts only when `busAddr` lies in [`baseReg`, `baseReg` + 2^`sizeLog2`). A request outside that window drives no strobe. `baseReg` is aligned to the block size.
- R2: A request is taken only when `reqStart` is high in the fast clock at phase 0 (phases 0,1,2,3 repeat from reset) and no access is running, or the running one is in its last tick. A request at any other phase is ignored.
- R3: Number the fast clocks after the accepting edge as ticks 0,1,2,... Chip select goes low at tick 4·relaxed + d. Here d is 0, 1 or 2 for a delay code (`optReg[1:0]`) of 0, 1 or 2, and a code of 3 acts as 2.
- R4: The relaxed bit (`optReg[3]`) adds four ticks, one bus clock, before chip select.
- R5: With the early-negate bit (`optReg[2]`), chip select and write enable go high two ticks before the end of the access. Output enable still lasts to the end.
- R6: The extended-hold bit (`optReg[4]`) adds one bus clock to an access only if it is the first access to the region. "First" means first since reset, or first after a request that fell outside the window.
- R7: In internal mode (`optReg[9]`=0), the last bus clock is n = relaxed + 1 + hold + W, where W is `optReg[8:5]` (0 to 15). `taOut` is high for ticks 4n to 4n+3. All strobes are released after tick 4n+3.
- R8: In external mode (`optReg[9]`=1), `taOut` stays low. `periphAck` is sampled in tick 4m+1 of each bus clock m from relaxed + 1 + hold onward. The first bus clock where it is high becomes the last one, and a high value earlier than that is ignored.
- R9: With `rdWr`=1 (read), output enable is low from the chip select tick to the end, and write enable stays high. With `rdWr`=0 (write), write enable follows chip select and output enable stays high. `rwOut` gives the access direction and is 1 when idle.
- R10: With the auto-burst-inhibit bit (`optReg[10]`), `burstInhOut` is high on every tick of an access in the window. Otherwise it stays low.
- R11: In reset and when idle: `csN`, `oeN`, `weN` and `rwOut` are 1, and `taOut` and `burstInhOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the bus rate |
| rst | input | 1 | Synchronous reset, active high |
| reqStart | input | 1 | Access request, sampled at phase 0 |
| busAddr | input | ADDR_W | Bus address |
| rdWr | input | 1 | Direction: 1 read, 0 write |
| periphAck | input | 1 | Peripheral acknowledge (external mode) |
| baseReg | input | ADDR_W | Region base address |
| sizeLog2 | input | SZ_W | Log2 of the region size in bytes |
| optReg | input | 11 | Option word (fields listed in R3 to R10) |
| csN | output | 1 | Chip select, active low |
| oeN | output | 1 | Output enable, active low |
| weN | output | 1 | Write enable, active low |
| rwOut | output | 1 | Direction line: 1 read, 0 write |
| taOut | output | 1 | Transfer acknowledge pulse |
| burstInhOut | output | 1 | Burst inhibit |

## Verification
Reads and writes run with each delay code, with and without relaxed setup. Shifts of one tick and of four ticks then show up directly in the chip select edge. Wait counts of 0, 5 and 15 test the length of the internal count. External accesses with the acknowledge raised early, or late, test the minimum-clock rule apart from the sampling point. A sequence of in-window access, out-of-window request and in-window access tests the first-access hold. Requests at a wrong phase, addresses at both window edges and back-to-back accesses cover the acceptance rules.

// File: rtl/cstg_pkg.sv
package cstg_pkg;

  // option word, most significant field first
  typedef struct packed {
    logic       autoBi;
    logic       extAck;
    logic [3:0] waits;
    logic       extHold;
    logic       relaxed;
    logic       earlyNeg;
    logic [1:0] csDly;
  } optCfg_t;

  localparam int OPT_W = $bits(optCfg_t);

  // strobes from control to datapath, valid for the next tick
  typedef struct packed {
    logic capture;
    logic miss;
    logic busy;
    logic csOn;
    logic oeWin;
    logic ta;
  } ctlStb_t;

  function automatic logic [4:0] firstClk(optCfg_t c, logic hold);
    return 5'(c.relaxed) + 5'd1 + 5'(hold);
  endfunction

  function automatic logic [4:0] lastClk(optCfg_t c, logic hold);
    return firstClk(c, hold) + 5'(c.waits);
  endfunction

  function automatic logic [2:0] csOffset(optCfg_t c);
    logic [2:0] q;
    q = (c.csDly == 2'd0) ? 3'd0 : (c.csDly == 2'd1) ? 3'd1 : 3'd2;
    return {c.relaxed, 2'b00} + q;
  endfunction

endpackage

// File: rtl/cstg_ctrl.sv
module cstg_ctrl
  import cstg_pkg::*;
#(
  parameter int TICK_W = 10
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqStart,
  input  logic    hit,
  input  logic    periphAck,
  input  optCfg_t cfgIn,
  input  logic    holdIn,
  output ctlStb_t stb
);
  localparam int CLK_W = TICK_W - 2;

  logic [1:0]        phaseQ;
  logic              busyQ, finalQ, holdQ;
  logic [TICK_W-1:0] tickQ, nt;
  optCfg_t           cfgQ, useCfg;
  logic              useHold;
  logic [CLK_W-1:0]  curClk, ntClk;
  logic              lastTick, slot, accept, ackHit, nextBusy, isFinal, active;

  assign curClk = tickQ[TICK_W-1:2];

  always_comb begin
    lastTick = busyQ && (tickQ[1:0] == 2'd3) &&
               (cfgQ.extAck ? finalQ : (curClk == CLK_W'(lastClk(cfgQ, holdQ))));
    slot     = reqStart && (phaseQ == 2'd0) && (!busyQ || lastTick);
    accept   = slot && hit;
    useCfg   = accept ? cfgIn : cfgQ;
    useHold  = accept ? holdIn : holdQ;
    ackHit   = busyQ && !finalQ && cfgQ.extAck && (tickQ[1:0] == 2'd1) &&
               (curClk >= CLK_W'(firstClk(cfgQ, holdQ))) && periphAck;
    nextBusy = accept || (busyQ && !lastTick);
    nt       = accept ? '0 : tickQ + TICK_W'(1);
    ntClk    = nt[TICK_W-1:2];
    isFinal  = useCfg.extAck ? (!accept && (finalQ || ackHit))
                             : (ntClk == CLK_W'(lastClk(useCfg, useHold)));
    active   = nt >= TICK_W'(csOffset(useCfg));

    stb.capture = accept;
    stb.miss    = slot && !hit;
    stb.busy    = nextBusy;
    stb.oeWin   = nextBusy && active;
    stb.csOn    = nextBusy && active &&
                  !(useCfg.earlyNeg && isFinal && nt[1]);
    stb.ta      = nextBusy && !useCfg.extAck && isFinal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= '0;
      busyQ  <= 1'b0;
      tickQ  <= '0;
      finalQ <= 1'b0;
      holdQ  <= 1'b0;
      cfgQ   <= '0;
    end else begin
      phaseQ <= phaseQ + 2'd1;
      busyQ  <= nextBusy;
      if (nextBusy) tickQ <= nt;
      if (accept) begin
        finalQ <= 1'b0;
        cfgQ   <= cfgIn;
        holdQ  <= holdIn;
      end else if (ackHit) begin
        finalQ <= 1'b1;
      end
    end
  end

  // R2: the tick count of a running access stays locked to the bus phase
  p_tick_phase_r2: assert property (@(posedge clk) disable iff (rst)
    busyQ |-> (tickQ[1:0] + 2'd1 == phaseQ));

endmodule

// File: rtl/cstg_dp.sv
module cstg_dp
  import cstg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [SZ_W-1:0]   sizeLog2,
  input  logic              rdWr,
  input  logic              autoBiIn,
  input  logic              extHoldIn,
  input  ctlStb_t           stb,
  output logic              hit,
  output logic              holdIn,
  output logic              csN,
  output logic              oeN,
  output logic              weN,
  output logic              rwOut,
  output logic              taOut,
  output logic              biOut
);
  logic [ADDR_W-1:0] diff;
  logic firstQ, rdQ, biQ, rdEff, biEff;

  assign diff   = busAddr ^ baseReg;
  assign hit    = (diff >> sizeLog2) == '0;
  assign holdIn = extHoldIn && firstQ;
  assign rdEff  = stb.capture ? rdWr : rdQ;
  assign biEff  = stb.capture ? autoBiIn : biQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      firstQ <= 1'b1;
      rdQ    <= 1'b1;
      biQ    <= 1'b0;
      csN    <= 1'b1;
      oeN    <= 1'b1;
      weN    <= 1'b1;
      rwOut  <= 1'b1;
      taOut  <= 1'b0;
      biOut  <= 1'b0;
    end else begin
      if (stb.capture)   firstQ <= 1'b0;
      else if (stb.miss) firstQ <= 1'b1;
      if (stb.capture) begin
        rdQ <= rdWr;
        biQ <= autoBiIn;
      end
      csN   <= ~stb.csOn;
      oeN   <= ~(stb.oeWin && rdEff);
      weN   <= ~(stb.csOn && !rdEff);
      rwOut <= stb.busy ? rdEff : 1'b1;
      taOut <= stb.ta;
      biOut <= stb.busy && biEff;
    end
  end

  // R9: read and write enables never overlap
  p_oe_we_excl_r9: assert property (@(posedge clk) disable iff (rst)
    oeN || weN);

  // R5: write enable is only ever low under chip select
  p_we_in_cs_r5: assert property (@(posedge clk) disable iff (rst)
    !weN |-> !csN);

  // R7: acknowledge holds once raised, and lasts a full bus clock
  p_ta_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(taOut) |=> taOut);

  p_ta_width_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(taOut) |-> $past(taOut, 4));

endmodule

// File: rtl/cs_timing_gen.sv
module cs_timing_gen
  import cstg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = $clog2(ADDR_W + 1),
  parameter int TICK_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqStart,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rdWr,
  input  logic              periphAck,
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [SZ_W-1:0]   sizeLog2,
  input  logic [10:0]       optReg,
  output logic              csN,
  output logic              oeN,
  output logic              weN,
  output logic              rwOut,
  output logic              taOut,
  output logic              burstInhOut
);
  optCfg_t cfgIn;
  ctlStb_t stb;
  logic    hit, holdIn;

  assign cfgIn = optCfg_t'(optReg);

  cstg_ctrl #(.TICK_W(TICK_W)) uCtrl (
    .clk(clk), .rst(rst), .reqStart(reqStart), .hit(hit),
    .periphAck(periphAck), .cfgIn(cfgIn), .holdIn(holdIn), .stb(stb)
  );

  cstg_dp #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) uDp (
    .clk(clk), .rst(rst), .busAddr(busAddr), .baseReg(baseReg),
    .sizeLog2(sizeLog2), .rdWr(rdWr), .autoBiIn(cfgIn.autoBi),
    .extHoldIn(cfgIn.extHold), .stb(stb), .hit(hit), .holdIn(holdIn),
    .csN(csN), .oeN(oeN), .weN(weN), .rwOut(rwOut), .taOut(taOut),
    .biOut(burstInhOut)
  );

endmodule

// File: tb/cs_timing_gen_test.sv
module cs_timing_gen_test;
  localparam int AW = 16;
  localparam int DEPTH = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqStart = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic rdWr = 1'b1;
  logic periphAck = 1'b0;
  logic [AW-1:0] baseReg = 16'h4000;
  logic [4:0] sizeLog2 = 5'd8;
  logic [10:0] optReg = '0;
  logic csN, oeN, weN, rwOut, taOut, burstInhOut;

  always #2 clk = ~clk;

  cs_timing_gen uut (
    .clk(clk), .rst(rst), .reqStart(reqStart), .busAddr(busAddr),
    .rdWr(rdWr), .periphAck(periphAck), .baseReg(baseReg),
    .sizeLog2(sizeLog2), .optReg(optReg), .csN(csN), .oeN(oeN),
    .weN(weN), .rwOut(rwOut), .taOut(taOut), .burstInhOut(burstInhOut)
  );

  bit expCs[DEPTH], expOe[DEPTH], expWe[DEPTH], expRw[DEPTH], expTa[DEPTH], expBi[DEPTH];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int freeFrom = 0;
  bit firstFlag = 1'b1;
  bit running = 1'b0;
  string curReq = "R11";

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(string name, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%b expected=%b cycle=%0d", curReq, name, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (running && !rst && cyc < DEPTH) begin
      chk("csN", csN, expCs[cyc]);
      chk("oeN", oeN, expOe[cyc]);
      chk("weN", weN, expWe[cyc]);
      chk("rwOut", rwOut, expRw[cyc]);
      chk("taOut", taOut, expTa[cyc]);
      chk("burstInhOut", burstInhOut, expBi[cyc]);
    end
  end

  function automatic logic [10:0] mk(int dly, bit en, bit rl, bit eh, int w, bit ext, bit bi);
    logic [3:0] w4 = w[3:0];
    logic [1:0] d2 = dly[1:0];
    return {bi, ext, w4, eh, rl, en, d2};
  endfunction

  task automatic waitSlot();
    while (!((cyc % 4 == 0) && (cyc + 1 >= freeFrom))) @(negedge clk);
  endtask

  // one request; ackFrom is the bus clock from which periphAck is held high
  task automatic access(logic [AW-1:0] addr, bit rd, logic [10:0] opt, int ackFrom, string req);
    int a, r, d, hold, mMin, m, csStart, hi;
    bit ext, en, inWin;
    waitSlot();
    curReq = req;
    busAddr = addr; rdWr = rd; optReg = opt; reqStart = 1'b1;
    a = cyc + 1;
    hi = int'(baseReg) + (1 << sizeLog2);
    inWin = (int'(addr) >= int'(baseReg)) && (int'(addr) < hi);
    if (!inWin) begin
      firstFlag = 1'b1;
      @(negedge clk);
      reqStart = 1'b0;
      return;
    end
    ext  = opt[9];
    en   = opt[2];
    r    = int'(opt[3]);
    d    = (opt[1:0] >= 2) ? 2 : int'(opt[1:0]);
    hold = (opt[4] && firstFlag) ? 1 : 0;
    firstFlag = 1'b0;
    mMin = r + 1 + hold;
    if (ext) m = (ackFrom > mMin) ? ackFrom : mMin;
    else     m = mMin + int'(opt[8:5]);
    csStart = 4 * r + d;
    for (int k = 0; k <= 4 * m + 3; k++) begin
      bit act = (k >= csStart);
      bit early = en && (k >= 4 * m + 2);
      if (a + k < DEPTH) begin
        expCs[a + k] = !(act && !early);
        expOe[a + k] = !(act && rd);
        expWe[a + k] = !(act && !rd && !early);
        expRw[a + k] = rd;
        expTa[a + k] = !ext && (k >= 4 * m);
        expBi[a + k] = opt[10];
      end
    end
    freeFrom = a + 4 * m + 4;
    @(negedge clk);
    reqStart = 1'b0;
    while (cyc <= a + 4 * m + 2) begin
      periphAck = ext && (cyc >= a + 4 * ackFrom);
      @(negedge clk);
    end
    periphAck = 1'b0;
  endtask

  // request placed at a non-zero phase while idle: must be ignored (R2)
  task automatic offPhaseRequest();
    while (!((cyc % 4 == 2) && (cyc + 1 >= freeFrom))) @(negedge clk);
    curReq = "R2";
    busAddr = 16'h4020; rdWr = 1'b1; optReg = mk(0, 0, 0, 1, 0, 0, 1);
    reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      expCs[i] = 1; expOe[i] = 1; expWe[i] = 1; expRw[i] = 1; expTa[i] = 0; expBi[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    curReq = "R11";
    chk("csN", csN, 1'b1); chk("oeN", oeN, 1'b1); chk("weN", weN, 1'b1);
    chk("rwOut", rwOut, 1'b1); chk("taOut", taOut, 1'b0); chk("burstInhOut", burstInhOut, 1'b0);
    rst = 1'b0;
    running = 1'b1;
    repeat (2) @(negedge clk);

    // R6: hold on first access, not on the second, again after an out-of-window request
    access(16'h4010, 1, mk(0, 0, 0, 1, 0, 0, 0), 0, "R6");
    access(16'h4010, 1, mk(0, 0, 0, 1, 0, 0, 0), 0, "R6");
    access(16'h5000, 1, mk(0, 0, 0, 1, 0, 0, 0), 0, "R6");
    access(16'h4010, 0, mk(1, 0, 0, 1, 1, 0, 0), 0, "R6");
    // R2: off-phase request ignored, and it does not re-arm the first-access flag
    offPhaseRequest();
    access(16'h4010, 1, mk(0, 0, 0, 1, 0, 0, 0), 0, "R6");
    // R3: delay codes
    access(16'h4004, 1, mk(0, 0, 0, 0, 1, 0, 0), 0, "R3");
    access(16'h4004, 1, mk(1, 0, 0, 0, 1, 0, 0), 0, "R3");
    access(16'h4004, 1, mk(2, 0, 0, 0, 1, 0, 0), 0, "R3");
    access(16'h4004, 1, mk(3, 0, 0, 0, 1, 0, 0), 0, "R3");
    // R4: relaxed setup
    access(16'h4008, 1, mk(1, 0, 1, 0, 0, 0, 0), 0, "R4");
    access(16'h4008, 0, mk(2, 0, 1, 0, 2, 0, 0), 0, "R4");
    // R5: early negation on write and read
    access(16'h4030, 0, mk(1, 1, 0, 0, 2, 0, 0), 0, "R5");
    access(16'h4030, 1, mk(0, 1, 0, 0, 0, 0, 0), 0, "R5");
    // R7: wait-state lengths
    access(16'h40A0, 1, mk(0, 0, 0, 0, 0, 0, 0), 0, "R7");
    access(16'h40A0, 0, mk(0, 0, 0, 0, 5, 0, 0), 0, "R7");
    access(16'h40A0, 1, mk(2, 0, 1, 0, 15, 0, 0), 0, "R7");
    // R8: peripheral terminates
    access(16'h4040, 1, mk(0, 0, 0, 0, 7, 1, 0), 0, "R8");
    access(16'h4040, 0, mk(1, 0, 0, 0, 0, 1, 0), 4, "R8");
    access(16'h4040, 1, mk(2, 1, 1, 0, 0, 1, 0), 2, "R8");
    // R9: direction
    access(16'h4050, 0, mk(0, 0, 0, 0, 1, 0, 0), 0, "R9");
    access(16'h4050, 1, mk(0, 0, 0, 0, 1, 0, 0), 0, "R9");
    // R10: burst inhibit
    access(16'h4060, 1, mk(1, 0, 0, 0, 1, 0, 1), 0, "R10");
    access(16'h4060, 0, mk(0, 0, 0, 0, 0, 1, 1), 1, "R10");
    // R1: window edges
    access(16'h40FF, 1, mk(0, 0, 0, 0, 0, 0, 1), 0, "R1");
    access(16'h4100, 1, mk(0, 0, 0, 0, 0, 0, 1), 0, "R1");
    access(16'h3FFF, 0, mk(0, 0, 0, 0, 0, 0, 1), 0, "R1");
    waitSlot();
    sizeLog2 = 5'd4;
    access(16'h4010, 1, mk(0, 0, 0, 0, 0, 0, 1), 0, "R1");
    access(16'h400F, 0, mk(0, 0, 0, 0, 0, 0, 1), 0, "R1");
    sizeLog2 = 5'd8;

    while (cyc < freeFrom + 8) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule